// File: doc/BRIEF.md
# Four-Way Write-Through Cache

This block sits between a processor port and a slower memory port and holds recently used memory lines for both instruction fetches and data accesses. It has 8 KB of storage arranged as 128 sets of four ways, each way a 16-byte line. Every line has its own tag and valid bit. Reads that find their line return the word in the cycle they are presented. Reads that miss hold the processor while the line is fetched from memory as four 32-bit words, after which the requested word is returned.

Writes are never held back in the cache. Each write produces exactly one single-word memory write, and the processor is released when memory acknowledges it. If the written line is cached, the cached word is changed too. A write that misses leaves the cache contents as they were.

On a read miss the line goes into an empty way of its set when one exists. Otherwise the way that has gone longest without use is replaced. A one-cycle invalidate input empties the whole cache.

Top module: `cache_wt_top`

## Requirements
- R1: A byte address is split as word-in-line = bits [3:2], set = bits [10:4] and tag = bits [31:11]. Lines in the same set that differ only in tag are held at the same time, and every word of a cached line hits.
- R2: A read that hits raises cpuReady in the same cycle as cpuReq, with no memory request, and returns the cached word.
- R3: A read that misses issues four read beats (memWe low). Their addresses are the line base, base+4, base+8 and base+12, in that order, and each beat completes on memAck. cpuReady stays low until all four beats have completed, and the returned word equals memory's word at the requested address.
- R4: Every write issues exactly one memory write carrying the processor's address and data. cpuReady is raised in the cycle memAck is high.
- R5: A write that hits updates the cached word, so a later read hits and returns the new value. A write that misses allocates nothing, so a later read of that address misses.
- R6: On a read miss, a way whose valid bit is clear is filled before any valid line is evicted.
- R7: When all four ways of the set are valid, the least recently used way is replaced. Read hits, write hits and refills each make their way the most recently used.
- R8: A cycle with flushAll high clears every valid bit, so each later read misses until it is refilled.
- R9: After reset all ways are invalid and cpuReady and memReq are low while no request is presented.
- R10: While memReq is high without memAck, memAddr and memWe hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flushAll | input | 1 | Clears all valid bits |
| cpuReq | input | 1 | Processor request, held until cpuReady |
| cpuWe | input | 1 | Request is a write |
| cpuAddr | input | 32 | Processor byte address, word aligned |
| cpuWdata | input | 32 | Processor write data |
| cpuRdata | output | 32 | Read data, valid with cpuReady on reads |
| cpuReady | output | 1 | Request completes this cycle |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | Memory beat is a write |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory beat completes this cycle |

## Verification
Random traffic is drawn from six tags over three sets, so each set is both reused and over-subscribed. This brings out hits, refills into empty ways, LRU evictions, and write hits mixed with write misses. A reference model of tags, valid bits and ages predicts hit or miss for each access, and a shadow memory predicts the data. A wrong victim, a stale cached word or a missing LRU update therefore appears as an unexpected refill count or a wrong value. Directed sequences cover three more cases: a four-tag fill followed by eviction order, a write followed by a read of the same word, and a flush followed by reads of lines that were cached. Memory acknowledges after random delays, which checks that refill beats wait correctly and arrive in order.

// File: rtl/cache_wt_pkg.sv
package cache_wt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } cacheState_t;

  typedef struct packed {
    logic latchVictim;
    logic fillWrite;
    logic fillDone;
    logic touchHit;
    logic writeHitUpd;
    logic memRead;
    logic memWrite;
    logic cpuAck;
  } cacheStrobe_t;

endpackage

// File: rtl/cache_wt_ctrl.sv
module cache_wt_ctrl
  import cache_wt_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int BEAT_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              hit,
  input  logic              memAck,
  output cacheStrobe_t      strobe,
  output logic [BEAT_W-1:0] beat
);

  cacheState_t state, stateNext;
  logic lastBeat;

  assign lastBeat = (beat == BEAT_W'(WORDS - 1));

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq && !cpuWe) begin
          if (hit) begin
            strobe.cpuAck   = 1'b1;
            strobe.touchHit = 1'b1;
          end else begin
            strobe.latchVictim = 1'b1;
            stateNext          = ST_FILL;
          end
        end else if (cpuReq && cpuWe) begin
          stateNext = ST_WRITE;
        end
      end
      ST_FILL: begin
        strobe.memRead = 1'b1;
        if (memAck) begin
          strobe.fillWrite = 1'b1;
          if (lastBeat) begin
            strobe.fillDone = 1'b1;
            stateNext       = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        strobe.memWrite = 1'b1;
        if (memAck) begin
          strobe.cpuAck      = 1'b1;
          strobe.writeHitUpd = hit;
          stateNext          = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      state <= stateNext;
      if (strobe.fillWrite) beat <= beat + 1'b1;
    end
  end

endmodule

// File: rtl/cache_wt_dpath.sv
module cache_wt_dpath
  import cache_wt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 128,
  parameter int WORDS  = 4,
  localparam int BEAT_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int OFF_W  = BYTE_W + BEAT_W,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  cacheStrobe_t      strobe,
  input  logic [BEAT_W-1:0] beat,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr
);

  logic [TAG_W-1:0]  tagMem  [SETS][WAYS];
  logic [WAYS-1:0]   validMem[SETS];
  logic [WAY_W-1:0]  ageMem  [SETS][WAYS];
  logic [DATA_W-1:0] dataMem [SETS][WAYS][WORDS];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [BEAT_W-1:0] word;
  logic [WAYS-1:0]   wayHit;
  logic [WAY_W-1:0]  hitWay, victimNext, victimReg, touchWay;
  logic [WAY_W-1:0]  touchAge;
  logic              anyInvalid, touchEn;

  assign idx  = cpuAddr[OFF_W +: IDX_W];
  assign tag  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign word = cpuAddr[BYTE_W +: BEAT_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validMem[idx][w] && (tagMem[idx][w] == tag);
  end

  assign hit = |wayHit;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (wayHit[w]) hitWay = WAY_W'(w);
  end

  // empty ways first, lowest index wins; otherwise the oldest way
  always_comb begin
    victimNext = '0;
    anyInvalid = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validMem[idx][w]) begin
        victimNext = WAY_W'(w);
        anyInvalid = 1'b1;
      end
    end
    if (!anyInvalid) begin
      for (int w = 0; w < WAYS; w++)
        if (ageMem[idx][w] == WAY_W'(WAYS - 1)) victimNext = WAY_W'(w);
    end
  end

  assign touchEn  = strobe.fillDone | strobe.touchHit | strobe.writeHitUpd;
  assign touchWay = strobe.fillDone ? victimReg : hitWay;
  assign touchAge = ageMem[idx][touchWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimReg <= '0;
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        for (int w = 0; w < WAYS; w++) ageMem[s][w] <= WAY_W'(w);
      end
    end else begin
      if (strobe.latchVictim) victimReg <= victimNext;
      if (flushAll) begin
        for (int s = 0; s < SETS; s++) begin
          validMem[s] <= '0;
          for (int w = 0; w < WAYS; w++) ageMem[s][w] <= WAY_W'(w);
        end
      end else begin
        if (strobe.fillDone) validMem[idx][victimReg] <= 1'b1;
        if (touchEn) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touchWay)
              ageMem[idx][w] <= '0;
            else if (ageMem[idx][w] < touchAge)
              ageMem[idx][w] <= ageMem[idx][w] + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWrite)   dataMem[idx][victimReg][beat] <= memRdata;
    if (strobe.fillDone)    tagMem[idx][victimReg]        <= tag;
    if (strobe.writeHitUpd) dataMem[idx][hitWay][word]    <= cpuWdata;
  end

  assign rdata   = dataMem[idx][hitWay][word];
  assign memAddr = strobe.memWrite ? cpuAddr
                 : {cpuAddr[ADDR_W-1:OFF_W], beat, {BYTE_W{1'b0}}};

endmodule

// File: rtl/cache_wt_top.sv
module cache_wt_top
  import cache_wt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 128,
  parameter int WORDS  = 4,
  localparam int BEAT_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  cacheStrobe_t      strobe;
  logic [BEAT_W-1:0] beat;
  logic              hit;

  cache_wt_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .memAck(memAck), .strobe(strobe), .beat(beat)
  );

  cache_wt_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .strobe(strobe), .beat(beat), .memRdata(memRdata),
    .hit(hit), .rdata(cpuRdata), .memAddr(memAddr)
  );

  assign cpuReady = strobe.cpuAck;
  assign memReq   = strobe.memRead | strobe.memWrite;
  assign memWe    = strobe.memWrite;
  assign memWdata = cpuWdata;

endmodule

// File: rtl/cache_wt_checker.sv
module cache_wt_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int BEAT_W = $clog2(WORDS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuWdata,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck
);

  a_r2_hit_no_memory: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuWe && cpuReady) |-> !memReq);

  a_r3_beat_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (memAddr[BYTE_W-1:0] == '0));

  a_r3_beat_order: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck && (memAddr[BYTE_W +: BEAT_W] != BEAT_W'(WORDS - 1)))
      |=> (memReq && !memWe && (memAddr == $past(memAddr) + ADDR_W'(DATA_W / 8))));

  a_r4_write_passes: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && cpuReady)
      |-> (memReq && memWe && memAck && (memAddr == cpuAddr) && (memWdata == cpuWdata)));

  a_r9_no_spurious_ready: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |-> !cpuReady);

  a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

endmodule

bind cache_wt_top cache_wt_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
) u_check (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .cpuWdata(cpuWdata), .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck)
);

// File: tb/cache_wt_top_bench.sv
module cache_wt_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushAll = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuReady;
  logic        memReq;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  always #10 clk = ~clk;

  cache_wt_top u_cache_wt_top (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // shadow memory
  logic [31:0] written [logic [31:0]];
  function automatic logic [31:0] baseWord(logic [31:0] a);
    return (a * 32'h0019_660D) ^ 32'hC0DE_1234;
  endfunction
  function automatic logic [31:0] memRead(logic [31:0] a);
    if (written.exists(a)) return written[a];
    return baseWord(a);
  endfunction

  // memory port activity seen during one access
  int          fillCnt, wrCnt;
  logic [31:0] fillAddr [8];
  logic [31:0] wrAddr, wrData;

  initial begin
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (memReq && ($urandom_range(0, 2) != 0)) begin
        memAck = 1'b1;
        if (memWe) begin
          written[memAddr] = memWdata;
          wrCnt++;
          wrAddr = memAddr;
          wrData = memWdata;
        end else begin
          memRdata = memRead(memAddr);
          if (fillCnt < 8) fillAddr[fillCnt] = memAddr;
          fillCnt++;
        end
      end
    end
  end

  // reference model of tags, valid bits and ages (from R1, R6, R7, R8)
  bit          refValid [128][4];
  logic [20:0] refTag   [128][4];
  int          refAge   [128][4];

  function automatic void refFlush();
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 4; w++) begin
        refValid[s][w] = 1'b0;
        refAge[s][w]   = w;
      end
  endfunction

  function automatic int refFind(logic [31:0] a);
    for (int w = 0; w < 4; w++)
      if (refValid[a[10:4]][w] && refTag[a[10:4]][w] == a[31:11]) return w;
    return -1;
  endfunction

  function automatic void refTouch(int s, int way);
    int old = refAge[s][way];
    for (int w = 0; w < 4; w++)
      if (w == way) refAge[s][w] = 0;
      else if (refAge[s][w] < old) refAge[s][w]++;
  endfunction

  function automatic void refApply(bit we, logic [31:0] a);
    int s = a[10:4];
    int w = refFind(a);
    if (w >= 0) begin
      refTouch(s, w);
    end else if (!we) begin
      int v = -1;
      for (int k = 3; k >= 0; k--) if (!refValid[s][k]) v = k;
      if (v < 0) for (int k = 0; k < 4; k++) if (refAge[s][k] == 3) v = k;
      refValid[s][v] = 1'b1;
      refTag[s][v]   = a[31:11];
      refTouch(s, v);
    end
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(bit we, logic [31:0] a, logic [31:0] wd, string req);
    bit expHit;
    int waits = 0;
    logic [31:0] got;
    expHit = (refFind(a) >= 0);
    @(negedge clk);
    fillCnt = 0;
    wrCnt   = 0;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    #1;
    while (!cpuReady && waits < 500) begin
      @(negedge clk);
      #1;
      waits++;
    end
    got = cpuRdata;
    @(negedge clk);
    cpuReq = 1'b0;
    cpuWe  = 1'b0;
    if (we) begin
      check(wrCnt == 1, "R4", "memory writes per write", wrCnt, 1);
      check(wrAddr == a && wrData == wd, "R4", "write address", wrAddr, a);
      check(fillCnt == 0, "R5", "refill beats on write", fillCnt, 0);
    end else begin
      check(got == memRead(a), expHit ? "R2" : "R3", "read data", got, memRead(a));
      if (expHit) begin
        check(waits == 0 && fillCnt == 0, req, "hit wait cycles", waits, 0);
      end else begin
        check(fillCnt == 4, req, "refill beats", fillCnt, 4);
        for (int k = 0; k < 4; k++)
          check(fillAddr[k] == {a[31:4], 2'(k), 2'b00}, "R3", "refill beat address",
                fillAddr[k], {a[31:4], 2'(k), 2'b00});
      end
    end
    refApply(we, a);
  endtask

  task automatic flushCache();
    @(negedge clk);
    flushAll = 1'b1;
    @(negedge clk);
    flushAll = 1'b0;
    refFlush();
  endtask

  function automatic logic [31:0] mkAddr(int t, int s, int w);
    return {21'(t), 7'(s), 2'(w), 2'b00};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    refFlush();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: quiet after reset
    check(cpuReady == 1'b0, "R9", "cpuReady after reset", 32'(cpuReady), 0);
    check(memReq == 1'b0, "R9", "memReq after reset", 32'(memReq), 0);
    access(1'b0, mkAddr(5, 3, 1), 0, "R9");  // first read misses

    // R1: same set, tags differ only in bit 11; other words of the line hit
    access(1'b0, mkAddr(4, 3, 0), 0, "R1");
    access(1'b0, mkAddr(5, 3, 3), 0, "R1");
    access(1'b0, mkAddr(4, 3, 2), 0, "R1");

    // R6/R7: fill four ways then evict in LRU order, write hit refreshes age
    access(1'b0, mkAddr(10, 9, 0), 0, "R6");
    access(1'b0, mkAddr(11, 9, 0), 0, "R6");
    access(1'b0, mkAddr(12, 9, 0), 0, "R6");
    access(1'b0, mkAddr(13, 9, 0), 0, "R6");
    access(1'b0, mkAddr(10, 9, 1), 0, "R7");
    access(1'b1, mkAddr(11, 9, 2), 32'hCAFE_0011, "R7");
    access(1'b0, mkAddr(14, 9, 0), 0, "R7");  // evicts tag 12
    access(1'b0, mkAddr(12, 9, 0), 0, "R7");  // evicts tag 13
    access(1'b0, mkAddr(11, 9, 2), 0, "R7");  // still cached
    access(1'b0, mkAddr(13, 9, 3), 0, "R7");

    // R5: write hit updates cache; write miss does not allocate
    access(1'b1, mkAddr(5, 3, 1), 32'h1234_ABCD, "R5");
    access(1'b0, mkAddr(5, 3, 1), 0, "R5");
    access(1'b1, mkAddr(77, 40, 2), 32'h0BAD_F00D, "R5");
    access(1'b0, mkAddr(77, 40, 2), 0, "R5");

    // R8: flush empties everything
    flushCache();
    access(1'b0, mkAddr(5, 3, 1), 0, "R8");
    access(1'b0, mkAddr(11, 9, 2), 0, "R8");

    // random mix over a small pool of tags and sets
    for (int i = 0; i < 400; i++) begin
      int sets [3] = '{3, 4, 77};
      bit we = ($urandom_range(0, 9) < 3);
      logic [31:0] a = mkAddr(32'h40 + $urandom_range(0, 5), sets[$urandom_range(0, 2)],
                              $urandom_range(0, 3));
      access(we, a, $urandom(), we ? "R4" : "R7");
      if (i == 250) flushCache();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule